// File: doc/BRIEF.md
# Hot-Swap Sequencing and Fault-Timer Controller

This controller sequences a pass switch while a board is plugged into a live supply. It reads comparator flags that have already been synchronised to its clock: supply in range, overvoltage, lockout clear, overcurrent, output low and gate fully driven. From these it decides when to drive the gate, when to release soft-start and when to report that power is good. A saturating digital accumulator takes the place of a timing capacitor. It moves only on a one-cycle tick strobe, except when it is cleared, which happens at once.

After power-up, the accumulator counts slowly up to a high threshold. It is then cleared, and the gate and soft-start are released in the same cycle. While overcurrent persists, the accumulator counts up quickly. The step is a base value plus eight times a drain-current code, and the code is ignored while the output sits below its isolation level. When overcurrent stops, the accumulator counts back down. If it reaches the threshold, the gate turns off. The controller then either latches off or runs a shutdown cooling cycle before retrying, as chosen by a variant select.

Overvoltage turns the gate off at once. It leaves the breaker count and power-good untouched, except during initial timing, where it clears the count.

Top module: `hot_swap_ctrl`

## Requirements
- R1: While `uv_ok_i` is low, the next clock edge forces the gate off, clears the timer to 0, deasserts power-good and returns the controller to idle.
- R2: From idle, initial timing begins on the edge after `uv_ok_i`, `lockout_ok_i` and not `ov_i` are all true. With `lockout_ok_i` low it stays idle with the timer at 0.
- R3: In the on phase, `ov_i` forces `gate_en_o` low in the same cycle. The timer keeps following its overcurrent rules, and `pgood_o` and `ss_rel_o` stay unchanged.
- R4: When `ov_i` falls in the on phase, `gate_en_o` returns high. During initial timing, `ov_i` clears the timer to 0 and holds it there, and counting resumes from 0 once `ov_i` falls.
- R5: Initial timing adds `SLOW_STEP` on each tick. On the edge after the timer reaches `TH_HI`, the timer clears to 0 and `gate_en_o` and `ss_rel_o` both rise.
- R6: In the on phase, with `oc_i` high, each tick adds `FAST_STEP + 8*drn_code_i`. The code term counts as 0 whenever `out_iso_i` is high.
- R7: In the on phase, with `oc_i` low, each tick subtracts `SLOW_STEP` and the timer holds at 0.
- R8: On the edge after the timer reaches `TH_HI` in the on phase, the gate and soft-start go low. With `auto_retry_i` low, the controller stays off with the timer frozen.
- R9: The latched-off state ends only through a high `tmr_clr_i`, a low `uv_ok_i` or a low `lockout_ok_i`. Each of these returns the controller to idle with the timer at 0, and a new start-up follows.
- R10: `pgood_o` sets on the edge where the on phase coincides with `out_low_i` and `gate_full_i` both high. It then stays high until R1 or a low `lockout_ok_i` clears it; a trip does not clear it.
- R11: With `auto_retry_i` high, a trip clears the timer and starts shutdown cooling. The timer counts up by `SLOW_STEP` until it reaches `TH_HI`, then down by `SLOW_STEP` until it reaches `TH_LO`, and the next edge clears it and re-enters initial timing.
- R12: The timer saturates at `2**ACC_W-1` instead of wrapping.
- R13: While `rst_ni` is low, the gate, soft-start and power-good outputs are low and the timer is 0, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_ok_i | input | 1 | Supply above its undervoltage level |
| ov_i | input | 1 | Supply above its overvoltage level |
| lockout_ok_i | input | 1 | Supply lockout released |
| oc_i | input | 1 | Sense drop above breaker level |
| out_low_i | input | 1 | Output voltage below its good level |
| gate_full_i | input | 1 | Gate comparator reports full drive |
| out_iso_i | input | 1 | Output under isolation level; drain term ignored |
| drn_code_i | input | DRN_W | Drain-current code |
| auto_retry_i | input | 1 | 1 selects auto-retry, 0 selects latch-off |
| tmr_clr_i | input | 1 | External timer clear, releases latch-off |
| tick_i | input | 1 | One-cycle timer strobe |
| gate_en_o | output | 1 | Pass switch gate enable |
| ss_rel_o | output | 1 | Soft-start release |
| pgood_o | output | 1 | Latched power-good |
| timer_o | output | ACC_W | Accumulator value |

## Verification
If the sequencer sits in the wrong phase, `gate_en_o` and `ss_rel_o` show it on the next edge. A wrong accumulator mode shows on `timer_o` at the next tick, as a step of the wrong size or sign or as a clear where a hold was expected. Threshold comparisons act one edge after the crossing, so an off-by-one in a threshold moves the gate release or the trip by exactly one cycle. The checks catch that because they sample at the exact cycle. Power-good errors stay visible until the next supply reset, because the flag is latched.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_ON, ST_LATCH, ST_COOL_UP, ST_COOL_DN
  } hsc_state_e;

  typedef enum logic [2:0] {
    TM_HOLD, TM_CLEAR, TM_SLOW_UP, TM_FAST_UP, TM_SLOW_DN
  } tmr_mode_e;
endpackage

// File: rtl/hsc_timer.sv
module hsc_timer
  import hsc_pkg::*;
#(
  parameter int ACC_W     = 16,
  parameter int DRN_W     = 6,
  parameter int SLOW_STEP = 1,
  parameter int FAST_STEP = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  tmr_mode_e        mode_i,
  input  logic [DRN_W-1:0] drn_code_i,
  input  logic             out_iso_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int EXT_W = ACC_W + DRN_W + 4;
  localparam logic [EXT_W-1:0] ACC_MAX  = {{(EXT_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};
  localparam logic [EXT_W-1:0] SLOW_EXT = EXT_W'(SLOW_STEP);
  localparam logic [EXT_W-1:0] FAST_EXT = EXT_W'(FAST_STEP);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [EXT_W-1:0] acc_ext, drn_term, up_step, up_sum;

  // drain term is forced to zero while output is isolated
  assign drn_term = out_iso_i ? '0 : EXT_W'({drn_code_i, 3'b000});
  assign acc_ext  = EXT_W'(acc_q);
  assign up_step  = (mode_i == TM_FAST_UP) ? (FAST_EXT + drn_term) : SLOW_EXT;
  assign up_sum   = acc_ext + up_step;

  always_comb begin
    acc_d = acc_q;
    unique case (mode_i)
      TM_CLEAR: acc_d = '0;
      TM_SLOW_UP, TM_FAST_UP:
        if (tick_i) acc_d = (up_sum > ACC_MAX) ? {ACC_W{1'b1}} : up_sum[ACC_W-1:0];
      TM_SLOW_DN:
        if (tick_i) acc_d = (acc_ext > SLOW_EXT) ? acc_q - SLOW_EXT[ACC_W-1:0] : '0;
      default: acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R12
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_SLOW_UP || mode_i == TM_FAST_UP) |=> acc_q >= $past(acc_q));

  // R7
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TM_SLOW_DN && acc_q == '0) |=> acc_q == '0);
endmodule

// File: rtl/hsc_seq.sv
module hsc_seq
  import hsc_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int TH_HI = 4000,
  parameter int TH_LO = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uv_ok_i,
  input  logic             lockout_ok_i,
  input  logic             ov_i,
  input  logic             oc_i,
  input  logic             auto_retry_i,
  input  logic             tmr_clr_i,
  input  logic [ACC_W-1:0] acc_i,
  output hsc_state_e       state_o,
  output tmr_mode_e        mode_o
);
  localparam logic [ACC_W-1:0] HI_L = ACC_W'(TH_HI);
  localparam logic [ACC_W-1:0] LO_L = ACC_W'(TH_LO);

  hsc_state_e state_q, state_d;
  tmr_mode_e  mode;
  logic       at_hi, at_lo, supply_ok;

  assign at_hi     = acc_i >= HI_L;
  assign at_lo     = acc_i <= LO_L;
  assign supply_ok = uv_ok_i && lockout_ok_i;

  always_comb begin
    state_d = state_q;
    mode    = TM_HOLD;
    if (!supply_ok) begin
      state_d = ST_IDLE;
      mode    = TM_CLEAR;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          mode = TM_CLEAR;
          if (!ov_i) state_d = ST_INIT;
        end
        ST_INIT: begin
          if (ov_i) mode = TM_CLEAR;
          else if (at_hi) begin
            mode    = TM_CLEAR;
            state_d = ST_ON;
          end else mode = TM_SLOW_UP;
        end
        ST_ON: begin
          if (at_hi) begin
            mode    = auto_retry_i ? TM_CLEAR : TM_HOLD;
            state_d = auto_retry_i ? ST_COOL_UP : ST_LATCH;
          end else if (oc_i) mode = TM_FAST_UP;
          else               mode = TM_SLOW_DN;
        end
        ST_LATCH: begin
          if (tmr_clr_i) begin
            mode    = TM_CLEAR;
            state_d = ST_IDLE;
          end
        end
        ST_COOL_UP: begin
          if (at_hi) begin
            mode    = TM_SLOW_DN;
            state_d = ST_COOL_DN;
          end else mode = TM_SLOW_UP;
        end
        ST_COOL_DN: begin
          if (at_lo) begin
            mode    = TM_CLEAR;
            state_d = ST_INIT;
          end else mode = TM_SLOW_DN;
        end
        default: begin
          mode    = TM_CLEAR;
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign mode_o  = mode;

  // R8
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH && supply_ok && !tmr_clr_i) |=> state_q == ST_LATCH);

  // R5
  init_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT && supply_ok && !ov_i && at_hi) |=> (state_q == ST_ON && acc_i == '0));
endmodule

// File: rtl/hsc_pgood.sv
module hsc_pgood (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic pgood_o
);
  logic pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pg_q <= 1'b0;
    else if (clr_i) pg_q <= 1'b0;
    else if (set_i) pg_q <= 1'b1;
  end

  assign pgood_o = pg_q;

  // R10
  pg_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_q && !clr_i) |=> pg_q);
endmodule

// File: rtl/hot_swap_ctrl.sv
module hot_swap_ctrl
  import hsc_pkg::*;
#(
  parameter int ACC_W     = 16,
  parameter int DRN_W     = 6,
  parameter int SLOW_STEP = 1,
  parameter int FAST_STEP = 40,
  parameter int TH_HI     = 4000,
  parameter int TH_LO     = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uv_ok_i,
  input  logic             ov_i,
  input  logic             lockout_ok_i,
  input  logic             oc_i,
  input  logic             out_low_i,
  input  logic             gate_full_i,
  input  logic             out_iso_i,
  input  logic [DRN_W-1:0] drn_code_i,
  input  logic             auto_retry_i,
  input  logic             tmr_clr_i,
  input  logic             tick_i,
  output logic             gate_en_o,
  output logic             ss_rel_o,
  output logic             pgood_o,
  output logic [ACC_W-1:0] timer_o
);
  hsc_state_e state;
  tmr_mode_e  mode;
  logic       pg_set, pg_clr;

  hsc_seq #(.ACC_W(ACC_W), .TH_HI(TH_HI), .TH_LO(TH_LO)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .uv_ok_i      (uv_ok_i),
    .lockout_ok_i (lockout_ok_i),
    .ov_i         (ov_i),
    .oc_i         (oc_i),
    .auto_retry_i (auto_retry_i),
    .tmr_clr_i    (tmr_clr_i),
    .acc_i        (timer_o),
    .state_o      (state),
    .mode_o       (mode)
  );

  hsc_timer #(.ACC_W(ACC_W), .DRN_W(DRN_W), .SLOW_STEP(SLOW_STEP),
              .FAST_STEP(FAST_STEP)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .mode_i     (mode),
    .drn_code_i (drn_code_i),
    .out_iso_i  (out_iso_i),
    .acc_o      (timer_o)
  );

  assign pg_clr = !uv_ok_i || !lockout_ok_i;
  assign pg_set = (state == ST_ON) && out_low_i && gate_full_i;

  hsc_pgood u_pgood (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (pg_clr),
    .set_i   (pg_set),
    .pgood_o (pgood_o)
  );

  // overvoltage masks the gate without touching sequencing state
  assign gate_en_o = (state == ST_ON) && !ov_i;
  assign ss_rel_o  = (state == ST_ON);

  // R1
  uv_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uv_ok_i |=> (!gate_en_o && !pgood_o && timer_o == '0));

  // R3
  ov_keeps_pg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_i && uv_ok_i && lockout_ok_i && pgood_o) |=> pgood_o);

  // R3
  ov_keeps_ss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_i && uv_ok_i && lockout_ok_i && ss_rel_o && timer_o < ACC_W'(TH_HI)) |=> ss_rel_o);
endmodule

// File: tb/hot_swap_ctrl_tb.sv
module hot_swap_ctrl_tb;
  localparam int ACC_W = 8;
  localparam int DRN_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic uv, ov, lock, oc, olow, gfull, iso, autor, clr, tick;
  logic [DRN_W-1:0] drn;
  logic gate, ss, pg;
  logic [ACC_W-1:0] tmr;

  always #2 clk = ~clk;

  hot_swap_ctrl #(.ACC_W(ACC_W), .DRN_W(DRN_W), .SLOW_STEP(1), .FAST_STEP(40),
                  .TH_HI(200), .TH_LO(20)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .uv_ok_i(uv), .ov_i(ov), .lockout_ok_i(lock),
    .oc_i(oc), .out_low_i(olow), .gate_full_i(gfull), .out_iso_i(iso),
    .drn_code_i(drn), .auto_retry_i(autor), .tmr_clr_i(clr), .tick_i(tick),
    .gate_en_o(gate), .ss_rel_o(ss), .pgood_o(pg), .timer_o(tmr)
  );

  // ctrl {uv,ov,lock,oc,olow,gfull,iso,auto,clr,tick} | drn | cycles | {gate,ss,pg} | timer
  localparam int NR = 31;
  localparam logic [33:0] VEC [NR] = '{
    {10'b1010000001, 4'd0,  9'd101, 3'b000, 8'd100}, // R5
    {10'b1010000001, 4'd0,  9'd100, 3'b000, 8'd200}, // R5
    {10'b1010000001, 4'd0,  9'd1,   3'b110, 8'd0},   // R5
    {10'b1010110001, 4'd0,  9'd1,   3'b111, 8'd0},   // R10
    {10'b1010000001, 4'd0,  9'd1,   3'b111, 8'd0},   // R10 R7
    {10'b1110000001, 4'd0,  9'd1,   3'b011, 8'd0},   // R3
    {10'b1010000001, 4'd0,  9'd1,   3'b111, 8'd0},   // R4
    {10'b1011001001, 4'd5,  9'd2,   3'b111, 8'd80},  // R6
    {10'b1111001001, 4'd5,  9'd1,   3'b011, 8'd120}, // R3
    {10'b1010000001, 4'd0,  9'd10,  3'b111, 8'd110}, // R7
    {10'b1011000001, 4'd5,  9'd1,   3'b111, 8'd190}, // R6
    {10'b1011000001, 4'd5,  9'd1,   3'b111, 8'd255}, // R12
    {10'b1011000001, 4'd5,  9'd1,   3'b001, 8'd255}, // R8
    {10'b1010000001, 4'd0,  9'd20,  3'b001, 8'd255}, // R8
    {10'b1010000011, 4'd0,  9'd1,   3'b001, 8'd0},   // R9
    {10'b1010000001, 4'd0,  9'd1,   3'b001, 8'd0},   // R9
    {10'b1010000001, 4'd0,  9'd50,  3'b001, 8'd50},  // R5
    {10'b1110000001, 4'd0,  9'd1,   3'b001, 8'd0},   // R4
    {10'b1110000001, 4'd0,  9'd5,   3'b001, 8'd0},   // R4
    {10'b1010000001, 4'd0,  9'd10,  3'b001, 8'd10},  // R4
    {10'b0010000001, 4'd0,  9'd1,   3'b000, 8'd0},   // R1
    {10'b1000000001, 4'd0,  9'd3,   3'b000, 8'd0},   // R2
    {10'b1010000101, 4'd0,  9'd202, 3'b110, 8'd0},   // R2
    {10'b1011000101, 4'd15, 9'd1,   3'b110, 8'd160}, // R6
    {10'b1011000101, 4'd15, 9'd1,   3'b110, 8'd255}, // R12
    {10'b1011000101, 4'd15, 9'd1,   3'b000, 8'd0},   // R11
    {10'b1010000101, 4'd0,  9'd200, 3'b000, 8'd200}, // R11
    {10'b1010000101, 4'd0,  9'd1,   3'b000, 8'd199}, // R11
    {10'b1010000101, 4'd0,  9'd179, 3'b000, 8'd20},  // R11
    {10'b1010000101, 4'd0,  9'd1,   3'b000, 8'd0},   // R11
    {10'b1010000101, 4'd0,  9'd201, 3'b110, 8'd0}    // R11
  };

  int checks = 0;
  int errors = 0;

  function automatic string row_req(int i);
    case (i)
      0, 1, 2, 16:            return "R5";
      3:                      return "R10";
      4, 9:                   return "R7";
      5, 8:                   return "R3";
      6, 17, 18, 19:          return "R4";
      7, 10, 23:              return "R6";
      11, 24:                 return "R12";
      12, 13:                 return "R8";
      14, 15:                 return "R9";
      20:                     return "R1";
      21, 22:                 return "R2";
      default:                return "R11";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(string req, int eg, int es, int ep, int et);
    chk(req, "gate_en", int'(gate), eg);
    chk(req, "ss_rel", int'(ss), es);
    chk(req, "pgood", int'(pg), ep);
    chk(req, "timer", int'(tmr), et);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    {uv, ov, lock, oc, olow, gfull, iso, autor, clr, tick} = '0;
    drn = '0;
    #1;
    chk_out("R13", 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int i = 0; i < NR; i++) begin
      {uv, ov, lock, oc, olow, gfull, iso, autor, clr, tick} = VEC[i][33:24];
      drn = VEC[i][23:20];
      repeat (int'(VEC[i][19:11])) @(posedge clk);
      #1;
      chk_out(row_req(i), int'(VEC[i][10]), int'(VEC[i][9]), int'(VEC[i][8]),
              int'(VEC[i][7:0]));
    end

    // R13: asynchronous reset mid-run while gate is on
    rst_n = 1'b0;
    #1;
    chk_out("R13", 0, 0, 0, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R8/R9: latch-off released by an undervoltage pulse
    {uv, ov, lock, oc, olow, gfull, iso, autor, clr, tick} = 10'b1010000001;
    drn = '0;
    repeat (202) @(posedge clk);
    #1 chk("R5", "gate_en", int'(gate), 1);
    oc = 1'b1; drn = 4'd15;
    repeat (3) @(posedge clk);
    #1 chk_out("R8", 0, 0, 0, 255);
    oc = 1'b0; uv = 1'b0;
    @(posedge clk);
    #1 chk_out("R9", 0, 0, 0, 0);
    uv = 1'b1;
    repeat (202) @(posedge clk);
    #1 chk("R9", "gate_en after uv pulse", int'(gate), 1);

    // R9: latch-off released by a lockout event
    oc = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk_out("R8", 0, 0, 0, 255);
    oc = 1'b0; lock = 1'b0;
    @(posedge clk);
    #1 chk_out("R9", 0, 0, 0, 0);
    lock = 1'b1;
    repeat (202) @(posedge clk);
    #1 chk("R9", "gate_en after lockout", int'(gate), 1);

    finish_run();
  end
endmodule